// File: doc/BRIEF.md
# Charger Status and Configuration-Lock Register Block

This block holds the eight sticky status flags of a serially programmed battery charger and the configuration registers that the host may rewrite. The charger core reports each condition as a one-cycle event pulse. The pulse sets a flag, and the flag stays set until the host reads the status byte. That read returns the flags and clears them in the same access. The upper half of the flags are faults. While any fault flag is set, the block pulls an active-low open-drain fault line. The lower half are warnings, which are recorded but never touch the line.

Five configuration bytes and a non-volatile programming control bit sit behind a lock. Until the host writes a one into bit 0 of the unlock register, writes to these registers are dropped and reads of them return zero. The block connects through a plain register port with address, strobes and data. In a system it normally sits behind a two-wire serial slave decoder. That decoder and the non-volatile storage are outside the block.

Top module: `chg_status_regs`

## Requirements
- R1: After reset every flag, configuration byte, unlock bit and programming bit is 0, and `flt_pull_low` is 0 (line released).
- R2: A pulse on `evt[i]` sets status bit i. The flags are, from bit 7 down to bit 0: battery over-voltage, full-charge timeout, cold (<0 °C), hot (>60 °C), die over-temperature, top-off timeout, input under-voltage, thermistor open. A set bit stays set without further pulses.
- R3: `flt_pull_low` is 1 exactly when any of status bits 7..4 (mask 0xF0) is set. Bits 3..0 never affect it.
- R4: A read of address 0x00 returns the flags in the same cycle and clears all of them at that clock edge. The line is released on the next cycle unless a fault is set again.
- R5: An event pulse in the same cycle as a clearing read wins: that bit is set after the edge. The read returns the value held before the edge.
- R6: The fault line stays pulled after the event pulse ends, until the status byte is read.
- R7: Configuration bytes at 0x02..0x06 accept writes only while the unlock bit is 1. A write made while locked leaves the byte unchanged. `cfg_q` carries byte 0x02+k in bits [8k+7:8k].
- R8: Bit 0 of address 0x12 is the programming control bit, driven on `nv_prog`. It is writable only while unlocked, and bits 7..1 read as 0.
- R9: Bit 0 of address 0x11 is the unlock bit. It is always writable and readable, and bits 7..1 read as 0.
- R10: Addresses 0x01, 0x07..0x10 and 0x13..0xFF read as 0x00 and ignore writes. The status byte at 0x00 ignores writes.
- R11: While locked, reads of 0x02..0x06 and 0x12 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 8 | Event pulses, one per status flag |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en`, else 0 |
| flt_pull_low | output | 1 | 1 = pull the open-drain fault line low |
| cfg_q | output | 40 | Configuration bytes 0x02..0x06, packed |
| nv_prog | output | 1 | Non-volatile programming control bit |

## Verification
The assertions watch, on every cycle, that a pulse always leaves its flag set and that set flags survive any cycle without a clearing read. They also check that a clearing read leaves exactly the bits pulsed in that cycle, that the fault line only rises after a fault-class pulse, and that configuration bytes never move while locked. The bench scenarios cover what needs a history of accesses: a locked write that is dropped and later found unchanged once unlocked, a read racing an event, the fault line held after its cause is gone, and the block returning to its reset state when reset is applied in the middle of a run.

// File: rtl/chg_stat_pkg.sv
package chg_stat_pkg;

  localparam int AW = 8;

  localparam logic [AW-1:0] A_STAT   = 8'h00;
  localparam logic [AW-1:0] A_CFG_LO = 8'h02;
  localparam logic [AW-1:0] A_UNLOCK = 8'h11;
  localparam logic [AW-1:0] A_NVCTL  = 8'h12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_CFG,
    SEL_UNLOCK,
    SEL_NVCTL
  } sel_e;

  // Next value of a sticky flag word: clear first, then set.
  // A set pulse therefore wins over a clear in the same cycle.
  function automatic logic [7:0] sticky_next(input logic [7:0] cur,
                                             input logic [7:0] set,
                                             input logic       clr);
    return (clr ? 8'h00 : cur) | set;
  endfunction

  // True when the address falls in the configuration window.
  function automatic logic in_cfg_window(input logic [AW-1:0] a,
                                         input int            n);
    return (a >= A_CFG_LO) && (int'(a) < int'(A_CFG_LO) + n);
  endfunction

endpackage

// File: rtl/chg_addr_dec.sv
module chg_addr_dec
  import chg_stat_pkg::*;
#(
  parameter int NUM_CFG = 5,
  localparam int IW = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic [AW-1:0]     addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              unlocked,
  output sel_e              sel,
  output logic [IW-1:0]     cfg_idx,
  output logic              stat_clr,
  output logic [NUM_CFG-1:0] cfg_we,
  output logic              unlock_we,
  output logic              nvctl_we
);

  logic cfg_hit;
  logic [AW-1:0] cfg_off;

  assign cfg_hit = in_cfg_window(addr, NUM_CFG);
  assign cfg_off = addr - A_CFG_LO;
  assign cfg_idx = cfg_off[IW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_STAT)                   sel = SEL_STAT;
    else if (addr == A_UNLOCK)            sel = SEL_UNLOCK;
    else if (cfg_hit && unlocked)         sel = SEL_CFG;
    else if (addr == A_NVCTL && unlocked) sel = SEL_NVCTL;
  end

  assign stat_clr  = rd_en && (sel == SEL_STAT);
  assign unlock_we = wr_en && (sel == SEL_UNLOCK);
  assign nvctl_we  = wr_en && (sel == SEL_NVCTL);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_we
    assign cfg_we[k] = wr_en && (sel == SEL_CFG) && (int'(cfg_idx) == k);
  end

endmodule

// File: rtl/chg_stat_sticky.sv
module chg_stat_sticky
  import chg_stat_pkg::*;
#(
  parameter int        DW         = 8,
  parameter logic [DW-1:0] FAULT_MASK = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          clr,
  output logic [DW-1:0] stat_q,
  output logic          fault_any
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= sticky_next(stat_q, evt, clr);
  end

  assign fault_any = |(stat_q & FAULT_MASK);

endmodule

// File: rtl/chg_cfg_bank.sv
module chg_cfg_bank #(
  parameter int DW      = 8,
  parameter int NUM_CFG = 5,
  parameter logic [NUM_CFG*DW-1:0] CFG_RST = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         wdata,
  input  logic [NUM_CFG-1:0]    cfg_we,
  input  logic                  unlock_we,
  input  logic                  nvctl_we,
  output logic [NUM_CFG*DW-1:0] cfg_flat,
  output logic                  unlock_q,
  output logic                  nvprog_q
);

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_flat[k*DW +: DW] <= CFG_RST[k*DW +: DW];
      else if (cfg_we[k]) cfg_flat[k*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      nvprog_q <= 1'b0;
    end else begin
      if (unlock_we) unlock_q <= wdata[0];
      if (nvctl_we)  nvprog_q <= wdata[0];
    end
  end

endmodule

// File: rtl/chg_status_regs.sv
module chg_status_regs
  import chg_stat_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NUM_CFG = 5,
  parameter logic [DW-1:0] FAULT_MASK = 8'hF0,
  localparam int CW = NUM_CFG * DW,
  localparam int IW = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          flt_pull_low,
  output logic [CW-1:0] cfg_q,
  output logic          nv_prog
);

  sel_e              sel;
  logic [IW-1:0]     cfg_idx;
  logic              stat_clr;
  logic [NUM_CFG-1:0] cfg_we;
  logic              unlock_we;
  logic              nvctl_we;
  logic              cfg_unlock;
  logic [DW-1:0]     stat_q;
  logic              fault_any;

  chg_addr_dec #(.NUM_CFG(NUM_CFG)) u_dec (
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .unlocked  (cfg_unlock),
    .sel       (sel),
    .cfg_idx   (cfg_idx),
    .stat_clr  (stat_clr),
    .cfg_we    (cfg_we),
    .unlock_we (unlock_we),
    .nvctl_we  (nvctl_we)
  );

  chg_stat_sticky #(.DW(DW), .FAULT_MASK(FAULT_MASK)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .clr       (stat_clr),
    .stat_q    (stat_q),
    .fault_any (fault_any)
  );

  chg_cfg_bank #(.DW(DW), .NUM_CFG(NUM_CFG)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (wdata),
    .cfg_we    (cfg_we),
    .unlock_we (unlock_we),
    .nvctl_we  (nvctl_we),
    .cfg_flat  (cfg_q),
    .unlock_q  (cfg_unlock),
    .nvprog_q  (nv_prog)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_STAT:   rdata = stat_q;
        SEL_CFG:    rdata = cfg_q[int'(cfg_idx)*DW +: DW];
        SEL_UNLOCK: rdata = {{(DW-1){1'b0}}, cfg_unlock};
        SEL_NVCTL:  rdata = {{(DW-1){1'b0}}, nv_prog};
        default:    rdata = '0;
      endcase
    end
  end

  assign flt_pull_low = fault_any;

endmodule

// File: rtl/chg_status_chk.sv
module chg_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  evt,
  input logic        rd_en,
  input logic [7:0]  addr,
  input logic [7:0]  rdata,
  input logic [7:0]  stat_q,
  input logic        stat_clr,
  input logic        flt_pull_low,
  input logic        cfg_unlock,
  input logic [39:0] cfg_q
);

  logic unimpl_addr;
  assign unimpl_addr = (addr == 8'h01) || (addr >= 8'h07 && addr <= 8'h10) ||
                       (addr > 8'h12);

  // R2: a pulse always leaves its flag set after the edge
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R2: without a clearing read, no set flag drops
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R4 / R5: after a clearing read only same-cycle pulses remain
  p_clear_keeps_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (stat_q == $past(evt)));

  // R3: the fault line only rises after a fault-class pulse
  p_pin_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_pull_low) |-> $past(|evt[7:4]));

  // R7: configuration bytes are frozen while locked
  p_locked_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlock |=> $stable(cfg_q));

  // R10: unimplemented addresses read as zero
  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unimpl_addr) |-> (rdata == 8'h00));

endmodule

bind chg_status_regs chg_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt          (evt),
  .rd_en        (rd_en),
  .addr         (addr),
  .rdata        (rdata),
  .stat_q       (stat_q),
  .stat_clr     (stat_clr),
  .flt_pull_low (flt_pull_low),
  .cfg_unlock   (cfg_unlock),
  .cfg_q        (cfg_q)
);

// File: tb/chg_status_regs_tb.sv
`timescale 1ns/1ps
module chg_status_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        flt_pull_low;
  logic [39:0] cfg_q;
  logic        nv_prog;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chg_status_regs dut_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .flt_pull_low(flt_pull_low),
    .cfg_q(cfg_q), .nv_prog(nv_prog)
  );

  // kind: 0 idle, 1 write, 2 read | addr | data | evt | expected rdata | pin after | req
  function automatic logic [38:0] mkv(input logic [1:0] k, input logic [7:0] a,
                                      input logic [7:0] d, input logic [7:0] e,
                                      input logic [7:0] x, input logic p,
                                      input logic [3:0] r);
    return {k, a, d, e, x, p, r};
  endfunction

  function automatic string rq(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  localparam int NV = 36;
  localparam logic [38:0] VEC [NV] = '{
    mkv(2, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1),
    mkv(0, 8'h00, 8'h00, 8'h01, 8'h00, 0, 3),
    mkv(2, 8'h00, 8'h00, 8'h00, 8'h01, 0, 4),
    mkv(2, 8'h00, 8'h00, 8'h00, 8'h00, 0, 4),
    mkv(0, 8'h00, 8'h00, 8'h80, 8'h00, 1, 3),
    mkv(0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 6),
    mkv(0, 8'h00, 8'h00, 8'h00, 8'h00, 1, 6),
    mkv(2, 8'h00, 8'h00, 8'h00, 8'h80, 0, 4),
    mkv(0, 8'h00, 8'h00, 8'h0C, 8'h00, 0, 3),
    mkv(0, 8'h00, 8'h00, 8'h20, 8'h00, 1, 3),
    mkv(2, 8'h00, 8'h00, 8'h10, 8'h2C, 1, 5),
    mkv(2, 8'h00, 8'h00, 8'h00, 8'h10, 0, 5),
    mkv(1, 8'h02, 8'hA5, 8'h00, 8'h00, 0, 7),
    mkv(2, 8'h02, 8'h00, 8'h00, 8'h00, 0, 11),
    mkv(1, 8'h11, 8'hFF, 8'h00, 8'h00, 0, 9),
    mkv(2, 8'h11, 8'h00, 8'h00, 8'h01, 0, 9),
    mkv(2, 8'h02, 8'h00, 8'h00, 8'h00, 0, 7),
    mkv(1, 8'h06, 8'h3C, 8'h00, 8'h00, 0, 7),
    mkv(2, 8'h06, 8'h00, 8'h00, 8'h3C, 0, 7),
    mkv(1, 8'h12, 8'hFF, 8'h00, 8'h00, 0, 8),
    mkv(2, 8'h12, 8'h00, 8'h00, 8'h01, 0, 8),
    mkv(1, 8'h01, 8'hFF, 8'h00, 8'h00, 0, 10),
    mkv(2, 8'h01, 8'h00, 8'h00, 8'h00, 0, 10),
    mkv(1, 8'h09, 8'h77, 8'h00, 8'h00, 0, 10),
    mkv(2, 8'h09, 8'h00, 8'h00, 8'h00, 0, 10),
    mkv(2, 8'h10, 8'h00, 8'h00, 8'h00, 0, 10),
    mkv(2, 8'h13, 8'h00, 8'h00, 8'h00, 0, 10),
    mkv(1, 8'h00, 8'hFF, 8'h00, 8'h00, 0, 10),
    mkv(2, 8'h00, 8'h00, 8'h00, 8'h00, 0, 10),
    mkv(1, 8'h11, 8'h00, 8'h00, 8'h00, 0, 9),
    mkv(2, 8'h06, 8'h00, 8'h00, 8'h00, 0, 11),
    mkv(2, 8'h12, 8'h00, 8'h00, 8'h00, 0, 11),
    mkv(1, 8'h06, 8'h11, 8'h00, 8'h00, 0, 7),
    mkv(1, 8'h11, 8'h01, 8'h00, 8'h00, 0, 9),
    mkv(2, 8'h06, 8'h00, 8'h00, 8'h3C, 0, 7),
    mkv(2, 8'h02, 8'h00, 8'h00, 8'h00, 0, 7)
  };

  task automatic chk(input string r, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // One access: drive at negedge, check rdata before the edge, pin after it.
  task automatic step(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] e, input logic [7:0] x, input logic p,
                      input string r, input bit chk_pin);
    @(negedge clk);
    evt = e; addr = a; wdata = d;
    wr_en = (k == 2'd1); rd_en = (k == 2'd2);
    #1;
    if (k == 2'd2) chk(r, "rdata", 64'(rdata), 64'(x));
    @(posedge clk);
    #1;
    evt = '0; wr_en = 1'b0; rd_en = 1'b0;
    if (chk_pin) chk(r, "flt_pull_low", 64'(flt_pull_low), 64'(p));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pin in reset", 64'(flt_pull_low), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      step(v[38:37], v[36:29], v[28:21], v[20:13], v[12:5], v[4], rq(v[3:0]), 1'b1);
    end

    // R2 / R3: every flag position, pin by fault class
    for (int i = 0; i < 8; i++) begin
      step(2'd0, 8'h00, 8'h00, 8'(1 << i), 8'h00, (i >= 4), "R3", 1'b1);
      step(2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R2", 1'b0);
      step(2'd2, 8'h00, 8'h00, 8'h00, 8'(1 << i), 1'b0, "R2", 1'b1);
    end

    chk("R7", "cfg_q byte 0x06", 64'(cfg_q[39:32]), 64'h3C);
    chk("R7", "cfg_q byte 0x02", 64'(cfg_q[7:0]), 64'h00);
    chk("R8", "nv_prog", 64'(nv_prog), 64'd1);

    // R1: reset in the middle of a run
    step(2'd0, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b1, "R3", 1'b1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1", "pin after reset", 64'(flt_pull_low), 64'd0);
    chk("R1", "cfg_q after reset", 64'(cfg_q), 64'd0);
    chk("R1", "nv_prog after reset", 64'(nv_prog), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    step(2'd2, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R1", 1'b1);
    step(2'd2, 8'h11, 8'h00, 8'h00, 8'h00, 1'b0, "R1", 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule